// File: doc/BRIEF.md
# Bidirectional Parallel/Serial Bus Register

This block holds one data word between two parallel buses, called A and B, and also accepts a single serial data line. Four control inputs choose its behaviour. A direction select picks which bus is the source and which is the destination. An A-bus enable can remove bus A from the transfer entirely. A parallel/serial select chooses between loading a whole word and shifting one bit in. An immediate/strobed select decides whether a parallel load waits for the shift/load strobe or tracks the source bus continuously. The block never drives a real tristate. Each bus has its own input port, its own output port and its own output-enable, and a pad ring or bus fabric outside the block resolves them.

All storage runs on one fast system clock. The shift/load strobe is a slow, possibly unrelated signal. It passes through a synchronizer, and only its rising edge is used, as a single-cycle enable. An "immediate" parallel load is made by capturing the source bus on every system clock cycle. The register therefore follows the source with one cycle of lag, and no strobe is needed.

Top module: `bus_xfer_reg`

## Requirements
- R1: An active-low synchronous reset clears the stored word to zero.
- R2: With `par_mode` low, each detected strobe edge shifts the word toward the high bit, so bit i+1 takes bit i. `ser_in` enters bit 0 and the old bit W-1 is lost.
- R3: Only a rising edge of `shift_strobe` counts, and it counts once. A strobe held high for many cycles causes exactly one shift or load. The word changes on the third system clock edge after the strobe is first seen high.
- R4: With `par_mode` high and `imm_load` low, the source bus is captured only on a detected strobe edge. Between edges, changes on the source bus leave the word unchanged.
- R5: With `par_mode` and `imm_load` both high, the word follows the source bus one system clock later, with no strobe.
- R6: With `dir_a2b` high, bus A is the source and bus B is the destination. With it low, bus B is the source and bus A is the destination.
- R7: With `a_en` low, bus A is never used. `a_oe` stays low, and a parallel load with `dir_a2b` high does not happen. Bus B is still driven from the held word in that case.
- R8: `b_oe` equals `dir_a2b`, and `a_oe` equals `a_en` AND NOT `dir_a2b`. This holds in every mode, so the two enables are never high together.
- R9: `ser_in` has no effect in any parallel mode.
- R10: Whenever a bus output-enable is high, that bus's data output carries the stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_en | input | 1 | Bus A enable |
| dir_a2b | input | 1 | 1: A is source and B is destination; 0: the reverse |
| par_mode | input | 1 | 1: parallel load; 0: serial shift |
| imm_load | input | 1 | 1: parallel load every cycle; 0: parallel load on the strobe |
| ser_in | input | 1 | Serial data bit |
| shift_strobe | input | 1 | Shift/load strobe, asynchronous to clk |
| a_in | input | W | Bus A input lines |
| a_out | output | W | Bus A output data |
| a_oe | output | 1 | Bus A output enable |
| b_in | input | W | Bus B input lines |
| b_out | output | W | Bus B output data |
| b_oe | output | 1 | Bus B output enable |

## Verification
The hardest case to reach is the parallel A-to-B setting with bus A disabled. No load may happen there, even with the strobe or immediate mode active, while bus B keeps showing the old word. The bench first loads a known word and then drives a different value on bus A in that setting, with both strobed and immediate loading. It also sweeps all sixteen control combinations, each with a strobe pulse, and gives the two buses and the serial bit distinct values. A load from the wrong bus, a shift where a load belongs, or a missing hold therefore shows up as a wrong word on the enabled output.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

  typedef enum logic [1:0] {
    ACT_HOLD   = 2'd0,
    ACT_SHIFT  = 2'd1,
    ACT_LOAD_A = 2'd2,
    ACT_LOAD_B = 2'd3
  } act_e;

  typedef struct packed {
    logic a_en;
    logic dir_a2b;
    logic par_mode;
    logic imm_load;
  } ctrl_t;

  // Source bus is usable: B always in B-to-A, A only when enabled.
  function automatic logic source_valid(input ctrl_t c);
    return c.dir_a2b ? c.a_en : 1'b1;
  endfunction

  function automatic logic drive_b(input ctrl_t c);
    return c.dir_a2b;
  endfunction

  function automatic logic drive_a(input ctrl_t c);
    return c.a_en & ~c.dir_a2b;
  endfunction

endpackage

// File: rtl/strobe_edge.sv
module strobe_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_in,
  output logic rise
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], strobe_in};
      prev_q <= sync_q[LAST];
    end
  end

  assign rise = sync_q[LAST] & ~prev_q;

  // R3: an edge enable lasts a single cycle
  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/mode_ctrl.sv
module mode_ctrl
  import xfer_pkg::*;
(
  input  ctrl_t ctrl,
  input  logic  rise,
  output act_e  act,
  output logic  a_oe,
  output logic  b_oe
);
  logic load_go;

  always_comb begin
    load_go = source_valid(ctrl) & (ctrl.imm_load | rise);
    act     = ACT_HOLD;
    if (!ctrl.par_mode) begin
      if (rise) act = ACT_SHIFT;
    end else if (load_go) begin
      act = ctrl.dir_a2b ? ACT_LOAD_A : ACT_LOAD_B;
    end
  end

  assign a_oe = drive_a(ctrl);
  assign b_oe = drive_b(ctrl);

endmodule

// File: rtl/shift_load_reg.sv
module shift_load_reg
  import xfer_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  act_e         act,
  input  logic         ser_in,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] q
);
  function automatic logic [W-1:0] shift_up(input logic [W-1:0] v, input logic s);
    return {v[W-2:0], s};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      unique case (act)
        ACT_SHIFT:  q <= shift_up(q, ser_in);
        ACT_LOAD_A: q <= a_in;
        ACT_LOAD_B: q <= b_in;
        default:    q <= q;
      endcase
    end
  end

  // R2: a shift moves every bit up by one and takes the serial bit at 0
  assert_shift_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_SHIFT) |=> (q[W-1:1] == $past(q[W-2:0]) && q[0] == $past(ser_in)));

  // R6: loads take the chosen bus
  assert_load_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_LOAD_A) |=> (q == $past(a_in)));
  assert_load_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_LOAD_B) |=> (q == $past(b_in)));

  // R4: no action, no change
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_HOLD) |=> $stable(q));

endmodule

// File: rtl/bus_xfer_reg.sv
module bus_xfer_reg
  import xfer_pkg::*;
#(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         a_en,
  input  logic         dir_a2b,
  input  logic         par_mode,
  input  logic         imm_load,
  input  logic         ser_in,
  input  logic         shift_strobe,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic         b_oe
);
  ctrl_t        ctrl;
  logic         strobe_rise;
  act_e         act;
  logic [W-1:0] word_q;

  assign ctrl = '{a_en: a_en, dir_a2b: dir_a2b, par_mode: par_mode, imm_load: imm_load};

  strobe_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe_in (shift_strobe),
    .rise      (strobe_rise)
  );

  mode_ctrl u_mode (
    .ctrl (ctrl),
    .rise (strobe_rise),
    .act  (act),
    .a_oe (a_oe),
    .b_oe (b_oe)
  );

  shift_load_reg #(.W(W)) u_reg (
    .clk    (clk),
    .rst_n  (rst_n),
    .act    (act),
    .ser_in (ser_in),
    .a_in   (a_in),
    .b_in   (b_in),
    .q      (word_q)
  );

  assign a_out = word_q;
  assign b_out = word_q;

  // R8: the two buses are never driven together
  assert_oe_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_oe && b_oe));

  // R7: bus A disabled means no drive on A and no load in A-to-B parallel
  assert_a_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !a_en |-> !a_oe);
  assert_no_load_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_en && dir_a2b && par_mode) |=> $stable(b_out));

  // R9: in parallel modes the word never takes a shifted form from the serial line
  assert_par_no_shift_R9: assert property (@(posedge clk) disable iff (!rst_n)
    par_mode |-> (act != ACT_SHIFT));

endmodule

// File: tb/tb_bus_xfer_reg.sv
module tb_bus_xfer_reg;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         a_en, dir_a2b, par_mode, imm_load, ser_in, shift_strobe;
  logic [W-1:0] a_in, b_in, a_out, b_out;
  logic         a_oe, b_oe;

  bus_xfer_reg #(.W(W), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .a_en(a_en), .dir_a2b(dir_a2b),
    .par_mode(par_mode), .imm_load(imm_load), .ser_in(ser_in),
    .shift_strobe(shift_strobe), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
  );

  always #5 clk = ~clk;

  typedef struct {
    logic [W-1:0] val;
    logic         aoe;
    logic         boe;
    string        tag;
  } exp_t;

  exp_t         sb[$];
  int           n_chk  = 0;
  int           n_fail = 0;
  logic [W-1:0] model  = '0;

  // Monitor: compares expected items with the ports, away from the active edge.
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      logic ok;
      e  = sb.pop_front();
      ok = (a_oe === e.aoe) && (b_oe === e.boe) &&
           (!e.boe || b_out === e.val) && (!e.aoe || a_out === e.val);
      n_chk++;
      if (!ok) begin
        n_fail++;
        $display("FAIL %s: a_oe=%b b_oe=%b a_out=%h b_out=%h, expected a_oe=%b b_oe=%b word=%h",
                 e.tag, a_oe, b_oe, a_out, b_out, e.aoe, e.boe, e.val);
      end
    end
  end

  task automatic expect_now(input string tag);
    exp_t e;
    e.val = model;
    e.boe = dir_a2b;
    e.aoe = a_en & ~dir_a2b;
    e.tag = tag;
    sb.push_back(e);
    wait (sb.size() == 0);
    @(posedge clk);
  endtask

  task automatic set_ctrl(input logic ae, input logic d, input logic p, input logic im);
    @(negedge clk);
    a_en = ae; dir_a2b = d; par_mode = p; imm_load = im;
    repeat (3) @(negedge clk);
  endtask

  // Strobe pulse; the model applies the effect of one edge.
  task automatic pulse(input int high_cycles);
    @(negedge clk);
    shift_strobe = 1'b1;
    repeat (high_cycles) @(negedge clk);
    shift_strobe = 1'b0;
    repeat (4) @(negedge clk);
    if (!par_mode)                      model = {model[W-2:0], ser_in};
    else if (dir_a2b && a_en)           model = a_in;
    else if (!dir_a2b)                  model = b_in;
  endtask

  task automatic shift_bit(input logic b);
    @(negedge clk);
    ser_in = b;
    pulse(4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; a_en = 1'b0; dir_a2b = 1'b1; par_mode = 1'b0; imm_load = 1'b0;
    ser_in = 1'b0; shift_strobe = 1'b0; a_in = '0; b_in = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    expect_now("R1 reset word zero, R8 enables");

    // R2: serial shift of a byte, watched on bus B
    for (int i = W - 1; i >= 0; i--) begin
      shift_bit(1'(8'hA5 >> i));
      expect_now("R2 serial shift step");
    end

    // R3: long strobe gives one step only
    @(negedge clk); ser_in = 1'b1;
    pulse(12);
    expect_now("R3 held strobe single step");

    // R3: latency of the edge path (third clock edge after strobe seen)
    @(negedge clk); ser_in = 1'b0; shift_strobe = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    n_chk++;
    if (b_out !== model) begin
      n_fail++;
      $display("FAIL R3 early change: b_out=%h expected %h", b_out, model);
    end
    @(posedge clk); #1;
    model = {model[W-2:0], 1'b0};
    n_chk++;
    if (b_out !== model) begin
      n_fail++;
      $display("FAIL R3 latency: b_out=%h expected %h", b_out, model);
    end
    @(negedge clk); shift_strobe = 1'b0;
    repeat (4) @(negedge clk);

    // R8: enables in serial modes with B-to-A
    set_ctrl(1'b1, 1'b0, 1'b0, 1'b0);
    expect_now("R8 serial B-to-A drives A, R10 data");
    set_ctrl(1'b0, 1'b0, 1'b0, 1'b0);
    expect_now("R8 R7 serial B-to-A with A off drives nothing");

    // R4: strobed load from A, ignored until the edge
    set_ctrl(1'b1, 1'b1, 1'b1, 1'b0);
    @(negedge clk); a_in = 8'h3C; b_in = 8'h99;
    repeat (6) @(negedge clk);
    expect_now("R4 no load without strobe");
    @(negedge clk); ser_in = 1'b1;
    pulse(3);
    expect_now("R4 R6 R9 strobed load from A");

    // R6: strobed load from B, seen on A
    set_ctrl(1'b1, 1'b0, 1'b1, 1'b0);
    @(negedge clk); b_in = 8'hC3;
    pulse(3);
    expect_now("R6 strobed load from B onto A");

    // R7: A disabled in A-to-B parallel, strobed and immediate
    set_ctrl(1'b0, 1'b1, 1'b1, 1'b0);
    @(negedge clk); a_in = 8'hFF;
    pulse(3);
    model = 8'hC3;
    expect_now("R7 strobed, A disabled, no load");
    set_ctrl(1'b0, 1'b1, 1'b1, 1'b1);
    expect_now("R7 immediate, A disabled, no load");

    // R5: immediate load follows the source
    set_ctrl(1'b1, 1'b1, 1'b1, 1'b1);
    model = a_in;
    expect_now("R5 immediate load from A");
    @(negedge clk); a_in = 8'h77; ser_in = 1'b0;
    @(negedge clk); @(negedge clk);
    model = 8'h77;
    expect_now("R5 R9 immediate follows A change");
    @(negedge clk); b_in = 8'h5A;
    set_ctrl(1'b1, 1'b0, 1'b1, 1'b1);
    model = 8'h5A;
    expect_now("R5 immediate load from B");

    // Sweep of every control combination with a strobe pulse
    for (int c = 0; c < 16; c++) begin
      @(negedge clk);
      a_in = 8'h10 + 8'(c * 7);
      b_in = 8'hE1 - 8'(c * 5);
      ser_in = c[0] ^ c[2];
      a_en = c[3]; dir_a2b = c[2]; par_mode = c[1]; imm_load = c[0];
      repeat (3) @(negedge clk);
      if (par_mode && imm_load) begin
        if (dir_a2b && a_en) model = a_in;
        else if (!dir_a2b)   model = b_in;
      end
      pulse(2);
      expect_now("R2 R4 R5 R6 R7 R8 R10 control sweep");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule